// File: doc/BRIEF.md
# Store-Buffer Entry Error Checker

This block examines one store-buffer entry at a time and decides whether it holds a data or address fault. A check is started in one of two ways. A purge request checks the entry as it leaves the buffer. A load request checks the entry when a load's byte range overlaps it.

The 64-bit entry data is held as two independent 32-bit halves. Each half has a 7-bit single-error-correct, double-error-detect check code. The entry's address and byte marks carry one parity bit.

The block classifies the result for the selected entry and gates it with the enable bits. When a report passes its gates, it drives an error type, the entry index, a privilege level and a trap/interrupt class for one cycle. A purge always produces an invalidate strobe for the purged entry. The first report is kept in a single capture record. Any further report that arrives while that record is held sets a multiple-error flag instead.

Top module: `sb_err_check`

## Requirements
- R1: An entry whose valid bit is 0 or whose ASI flag is 1 is never checked. For such an entry, neither a purge nor a load request produces a report or an invalidate strobe.
- R2: Each 32-bit half uses a code placed at positions 1..38. Data bit j goes to the j-th position that is not a power of two, counting from 3. Check bit k (0..5) is the XOR of the data bits whose position has bit k set. Check bit 6 is the XOR of all 32 data bits and check bits 0..5.
- R2 (classification): A half whose total parity over data and all 7 check bits is odd has a correctable error. A half with even parity and a nonzero 6-bit syndrome has an uncorrectable error.
- R2 (precedence): An uncorrectable error in either half outranks a correctable error in either half. A disabled uncorrectable error therefore does not fall through to a correctable report.
- R3: On purge, an uncorrectable data error is reported as type 1, class 1 (software-recoverable) only when enable bits 0 and 1 are both set.
- R4: On purge, a correctable data error is reported as type 2, class 2 (hardware-corrected) only when enable bits 2 and 3 are both set.
- R5: On purge, a mismatch between the stored parity bit and the XOR of address and byte marks is reported as type 3, class 3 (trap), regardless of any data error. Its privilege output is the highest control level among all valid entries. Control encodings are user 3'b001 (reported 0), privileged 3'b010 (1) and hyperprivileged 3'b100 (2). Reports other than type 3 carry privilege 0.
- R6: If any valid entry holds a control code other than the three legal ones, a type 3 report carries privilege 3 (unknown).
- R7: Every purge of a valid, non-ASI entry raises the invalidate strobe with that entry's index, whether or not an error was found.
- R8: A load overlaps an entry when the load start is at or below the entry end, and the load start plus size is at or above the entry start. Entry start and end are the entry address plus the indices of its lowest and highest set byte mark. An entry with no byte marks never overlaps.
- R9: On an overlapping load, an uncorrectable error gives type 4 and a correctable error gives type 5, both class 3 (trap) with the entry index. The uncorrectable case needs enable bits 4 and 6; the correctable case needs enable bits 5 and 6. A load never invalidates.
- R10: Reports and strobes appear on the outputs one clock after the request. They last one cycle, and all report outputs are zero when no report is made.
- R11: The first report is held in the record until it is cleared. A report that arrives while the record is held sets the multiple-error flag and leaves the record unchanged. A clear in the same cycle as a report captures the new report with the flag at 0.
- R12: A load request ignores the address parity bit. A load with no overlap, or with clean data, produces no report.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_vld_i | input | 1 | Check request strobe |
| req_op_i | input | 1 | 0 = purge check, 1 = load-overlap check |
| ent_idx_i | input | IDX_W | Index of the entry under check |
| ent_addr_i | input | ADDR_W | Entry base address |
| ent_bmask_i | input | BM_W | Entry byte marks |
| ent_cpar_i | input | 1 | Stored parity of address and byte marks |
| ent_data_i | input | 64 | Entry data, low half in bits 31:0 |
| ent_ecc_i | input | 14 | Check codes, low half in bits 6:0, high half in 13:7 |
| valid_i | input | NUM_ENT | Valid flag per entry |
| asi_i | input | NUM_ENT | ASI flag per entry |
| ctl_i | input | 3*NUM_ENT | Control code per entry, entry e at bits 3e+2:3e |
| en_i | input | 7 | Error-class enables, bits as in R3, R4, R9 |
| ld_addr_i | input | ADDR_W | Load start address |
| ld_size_i | input | SZ_W | Load size added to the start |
| rec_clr_i | input | 1 | Clears the capture record |
| evt_o | output | 1 | Report strobe |
| err_type_o | output | 3 | Error type code |
| err_idx_o | output | IDX_W | Entry index of the report |
| priv_o | output | 2 | Privilege code of the report |
| class_o | output | 2 | Trap/interrupt class |
| inval_o | output | 1 | Invalidate strobe |
| inval_idx_o | output | IDX_W | Entry to invalidate |
| rec_vld_o | output | 1 | Record holds a report |
| rec_type_o | output | 3 | Recorded error type |
| rec_idx_o | output | IDX_W | Recorded entry index |
| rec_priv_o | output | 2 | Recorded privilege code |
| rec_multi_o | output | 1 | Further report seen while the record was held |

## Verification
The assertions rely on a few input conventions.
- The entry index must always be below the number of entries, so that the valid and ASI lookups refer to a real entry.
- The request strobe and the record clear must be low during reset. The checks that look one cycle back then see defined values on the first edge after reset.

The stimulus keeps within these conventions. It uses only indices 0 to 7, holds every request input at zero while reset is applied, and changes inputs on the falling clock edge. It builds every codeword with its own encoder and then flips chosen bits to produce the single and double faults.

// File: rtl/sbec_pkg.sv
package sbec_pkg;
  localparam int HALF_W   = 32;
  localparam int HAM_W    = 6;
  localparam int CHK_W    = HAM_W + 1;
  localparam int NUM_HALF = 2;
  localparam int CODE_MAX = HALF_W + HAM_W;
  localparam int CTL_W    = 3;
  localparam int EN_W     = 7;

  localparam int EN_PG_UE  = 0;
  localparam int EN_DEFER  = 1;
  localparam int EN_PG_CE  = 2;
  localparam int EN_CORR   = 3;
  localparam int EN_LD_UE  = 4;
  localparam int EN_LD_CE  = 5;
  localparam int EN_PRECIS = 6;

  localparam logic [CTL_W-1:0] CTL_USER  = 3'b001;
  localparam logic [CTL_W-1:0] CTL_PRIV  = 3'b010;
  localparam logic [CTL_W-1:0] CTL_HPRIV = 3'b100;

  typedef enum logic [2:0] {
    ET_NONE, ET_PURGE_UE, ET_PURGE_CE, ET_CAM_PAR, ET_LOAD_UE, ET_LOAD_CE
  } err_type_e;

  typedef enum logic [1:0] {CL_NONE, CL_SW_RECOV, CL_HW_CORR, CL_TRAP} class_e;

  typedef enum logic [1:0] {PV_USER, PV_PRIV, PV_HPRIV, PV_UNKNOWN} priv_e;

  // Check code: data fills non-power-of-two positions, bit 6 is overall parity
  function automatic logic [CHK_W-1:0] ecc_gen(input logic [HALF_W-1:0] d);
    logic [HAM_W-1:0] h;
    int j;
    h = '0;
    j = 0;
    for (int p = 1; p <= CODE_MAX; p++) begin
      if ((p & (p - 1)) != 0) begin
        for (int k = 0; k < HAM_W; k++) begin
          if (((p >> k) & 1) == 1) h[k] = h[k] ^ d[j];
        end
        j++;
      end
    end
    return {(^d) ^ (^h), h};
  endfunction
endpackage

// File: rtl/sbec_secded.sv
module sbec_secded
  import sbec_pkg::*;
(
  input  logic [HALF_W-1:0] data_i,
  input  logic [CHK_W-1:0]  ecc_i,
  output logic              ue_o,
  output logic              ce_o
);
  logic [CHK_W-1:0] calc;
  logic [HAM_W-1:0] syn;
  logic             pty;

  always_comb begin
    calc = ecc_gen(data_i);
    syn  = calc[HAM_W-1:0] ^ ecc_i[HAM_W-1:0];
    pty  = (^data_i) ^ (^ecc_i);
    ce_o = pty;
    ue_o = !pty && (syn != '0);
  end
endmodule

// File: rtl/sbec_overlap.sv
module sbec_overlap #(
  parameter int ADDR_W = 16,
  parameter int BM_W   = 8,
  parameter int SZ_W   = 4
) (
  input  logic [ADDR_W-1:0] ent_addr_i,
  input  logic [BM_W-1:0]   bm_i,
  input  logic [ADDR_W-1:0] ld_addr_i,
  input  logic [SZ_W-1:0]   ld_size_i,
  output logic              hit_o
);
  localparam int BM_IW = $clog2(BM_W);
  localparam int W     = ADDR_W + 1;

  logic [BM_IW-1:0] lo, hi;
  logic [W-1:0]     e_start, e_end, l_start, l_end;

  always_comb begin
    lo = '0;
    hi = '0;
    for (int i = BM_W - 1; i >= 0; i--) if (bm_i[i]) lo = BM_IW'(i);
    for (int i = 0; i < BM_W; i++) if (bm_i[i]) hi = BM_IW'(i);
    e_start = W'(ent_addr_i) + W'(lo);
    e_end   = W'(ent_addr_i) + W'(hi);
    l_start = W'(ld_addr_i);
    l_end   = W'(ld_addr_i) + W'(ld_size_i);
    hit_o   = (|bm_i) && (l_start <= e_end) && (l_end >= e_start);
  end
endmodule

// File: rtl/sbec_priv_scan.sv
module sbec_priv_scan
  import sbec_pkg::*;
#(
  parameter int NUM_ENT = 8
) (
  input  logic [NUM_ENT-1:0]       valid_i,
  input  logic [NUM_ENT*CTL_W-1:0] ctl_i,
  output logic [1:0]               priv_o
);
  logic [1:0] rank;
  logic       bad;

  always_comb begin
    rank = PV_USER;
    bad  = 1'b0;
    for (int e = 0; e < NUM_ENT; e++) begin
      if (valid_i[e]) begin
        case (ctl_i[e*CTL_W +: CTL_W])
          CTL_USER:  ;
          CTL_PRIV:  if (rank < PV_PRIV) rank = PV_PRIV;
          CTL_HPRIV: rank = PV_HPRIV;
          default:   bad = 1'b1;
        endcase
      end
    end
    priv_o = bad ? PV_UNKNOWN : rank;
  end
endmodule

// File: rtl/sb_err_check.sv
module sb_err_check
  import sbec_pkg::*;
#(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = $clog2(NUM_ENT),
  parameter int ADDR_W  = 16,
  parameter int BM_W    = 8,
  parameter int SZ_W    = 4
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     req_vld_i,
  input  logic                     req_op_i,
  input  logic [IDX_W-1:0]         ent_idx_i,
  input  logic [ADDR_W-1:0]        ent_addr_i,
  input  logic [BM_W-1:0]          ent_bmask_i,
  input  logic                     ent_cpar_i,
  input  logic [63:0]              ent_data_i,
  input  logic [13:0]              ent_ecc_i,
  input  logic [NUM_ENT-1:0]       valid_i,
  input  logic [NUM_ENT-1:0]       asi_i,
  input  logic [NUM_ENT*3-1:0]     ctl_i,
  input  logic [6:0]               en_i,
  input  logic [ADDR_W-1:0]        ld_addr_i,
  input  logic [SZ_W-1:0]          ld_size_i,
  input  logic                     rec_clr_i,
  output logic                     evt_o,
  output logic [2:0]               err_type_o,
  output logic [IDX_W-1:0]         err_idx_o,
  output logic [1:0]               priv_o,
  output logic [1:0]               class_o,
  output logic                     inval_o,
  output logic [IDX_W-1:0]         inval_idx_o,
  output logic                     rec_vld_o,
  output logic [2:0]               rec_type_o,
  output logic [IDX_W-1:0]         rec_idx_o,
  output logic [1:0]               rec_priv_o,
  output logic                     rec_multi_o
);
  logic [NUM_HALF-1:0] ue_h, ce_h;
  logic                ue, ce, par_bad, hit, sel_ok, rpt, purge;
  logic [1:0]          scan_priv;
  err_type_e           nt;
  class_e              nc;
  logic [1:0]          np;

  for (genvar h = 0; h < NUM_HALF; h++) begin : g_half
    sbec_secded u_half (
      .data_i (ent_data_i[h*HALF_W +: HALF_W]),
      .ecc_i  (ent_ecc_i[h*CHK_W +: CHK_W]),
      .ue_o   (ue_h[h]),
      .ce_o   (ce_h[h])
    );
  end

  sbec_overlap #(.ADDR_W(ADDR_W), .BM_W(BM_W), .SZ_W(SZ_W)) u_ovl (
    .ent_addr_i (ent_addr_i),
    .bm_i       (ent_bmask_i),
    .ld_addr_i  (ld_addr_i),
    .ld_size_i  (ld_size_i),
    .hit_o      (hit)
  );

  sbec_priv_scan #(.NUM_ENT(NUM_ENT)) u_priv (
    .valid_i (valid_i),
    .ctl_i   (ctl_i),
    .priv_o  (scan_priv)
  );

  assign sel_ok  = valid_i[ent_idx_i] && !asi_i[ent_idx_i];
  assign ue      = |ue_h;
  assign ce      = !ue && (|ce_h);
  assign par_bad = ((^ent_addr_i) ^ (^ent_bmask_i)) != ent_cpar_i;
  assign purge   = req_vld_i && !req_op_i && sel_ok;

  always_comb begin
    nt = ET_NONE;
    nc = CL_NONE;
    np = PV_USER;
    if (!req_op_i) begin
      if (par_bad) begin
        nt = ET_CAM_PAR;
        nc = CL_TRAP;
        np = scan_priv;
      end else if (ue) begin
        if (en_i[EN_PG_UE] && en_i[EN_DEFER]) begin
          nt = ET_PURGE_UE;
          nc = CL_SW_RECOV;
        end
      end else if (ce && en_i[EN_PG_CE] && en_i[EN_CORR]) begin
        nt = ET_PURGE_CE;
        nc = CL_HW_CORR;
      end
    end else if (hit) begin
      if (ue) begin
        if (en_i[EN_LD_UE] && en_i[EN_PRECIS]) begin
          nt = ET_LOAD_UE;
          nc = CL_TRAP;
        end
      end else if (ce && en_i[EN_LD_CE] && en_i[EN_PRECIS]) begin
        nt = ET_LOAD_CE;
        nc = CL_TRAP;
      end
    end
  end

  assign rpt = req_vld_i && sel_ok && (nt != ET_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      evt_o       <= 1'b0;
      err_type_o  <= ET_NONE;
      err_idx_o   <= '0;
      priv_o      <= PV_USER;
      class_o     <= CL_NONE;
      inval_o     <= 1'b0;
      inval_idx_o <= '0;
    end else begin
      evt_o       <= rpt;
      err_type_o  <= rpt ? nt : ET_NONE;
      err_idx_o   <= rpt ? ent_idx_i : '0;
      priv_o      <= rpt ? np : PV_USER;
      class_o     <= rpt ? nc : CL_NONE;
      inval_o     <= purge;
      inval_idx_o <= purge ? ent_idx_i : '0;
    end
  end

  // Single capture record; later reports only flag multiplicity
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rec_vld_o   <= 1'b0;
      rec_type_o  <= ET_NONE;
      rec_idx_o   <= '0;
      rec_priv_o  <= PV_USER;
      rec_multi_o <= 1'b0;
    end else begin
      if (rec_clr_i) begin
        rec_vld_o   <= 1'b0;
        rec_multi_o <= 1'b0;
      end
      if (rpt) begin
        if (rec_vld_o && !rec_clr_i) begin
          rec_multi_o <= 1'b1;
        end else begin
          rec_vld_o  <= 1'b1;
          rec_type_o <= nt;
          rec_idx_o  <= ent_idx_i;
          rec_priv_o <= np;
        end
      end
    end
  end
endmodule

// File: rtl/sb_err_check_chk.sv
module sb_err_check_chk #(
  parameter int NUM_ENT = 8,
  parameter int IDX_W   = 3
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic               req_vld_i,
  input logic               req_op_i,
  input logic [IDX_W-1:0]   ent_idx_i,
  input logic [NUM_ENT-1:0] valid_i,
  input logic [NUM_ENT-1:0] asi_i,
  input logic               rec_clr_i,
  input logic               evt_o,
  input logic [2:0]         err_type_o,
  input logic [1:0]         priv_o,
  input logic               inval_o,
  input logic               rec_vld_o,
  input logic [2:0]         rec_type_o,
  input logic [IDX_W-1:0]   rec_idx_o,
  input logic               rec_multi_o
);
  a_r1_only_checked_entries: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(valid_i[ent_idx_i] && !asi_i[ent_idx_i]));

  a_r10_evt_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_o |-> $past(req_vld_i));

  a_r7_inval_after_purge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inval_o |-> $past(req_vld_i && !req_op_i));

  a_r9_load_no_inval: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && (err_type_o == 3'd4 || err_type_o == 3'd5)) |-> !inval_o);

  a_r5_priv_only_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_o && err_type_o != 3'd3) |-> priv_o == 2'd0);

  a_r11_multi_needs_rec: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_multi_o |-> rec_vld_o);

  a_r11_rec_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rec_vld_o && !rec_clr_i) |=> (rec_vld_o && $stable(rec_type_o) && $stable(rec_idx_o)));
endmodule

bind sb_err_check sb_err_check_chk #(.NUM_ENT(NUM_ENT), .IDX_W(IDX_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_vld_i   (req_vld_i),
  .req_op_i    (req_op_i),
  .ent_idx_i   (ent_idx_i),
  .valid_i     (valid_i),
  .asi_i       (asi_i),
  .rec_clr_i   (rec_clr_i),
  .evt_o       (evt_o),
  .err_type_o  (err_type_o),
  .priv_o      (priv_o),
  .inval_o     (inval_o),
  .rec_vld_o   (rec_vld_o),
  .rec_type_o  (rec_type_o),
  .rec_idx_o   (rec_idx_o),
  .rec_multi_o (rec_multi_o)
);

// File: tb/sb_err_check_bench.sv
module sb_err_check_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 27;

  typedef struct packed {
    logic        op;
    logic [2:0]  idx;
    logic [7:0]  valid;
    logic [7:0]  asi;
    logic [15:0] addr;
    logic [7:0]  bm;
    logic [63:0] data;
    logic [7:0]  fa;
    logic [7:0]  fb;
    logic [7:0]  fc;
    logic        pflip;
    logic [23:0] ctl;
    logic [6:0]  en;
    logic [15:0] ld_addr;
    logic [3:0]  ld_size;
    logic [2:0]  x_type;
    logic [1:0]  x_cls;
    logic [1:0]  x_priv;
    logic        x_inv;
    logic [3:0]  req;
  } vec_t;

  localparam logic [63:0] D0 = 64'hDEAD_BEEF_0123_4567;
  localparam logic [63:0] D1 = 64'h5A5A_0F0F_C3C3_9669;
  localparam logic [23:0] CU = 24'h249249;

  // flip index: 0..63 data, 64..70 low check code, 71..77 high check code
  localparam vec_t VECS [NV] = '{
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'hFF,8'hFF,8'hFF,0,CU,7'h7F,16'h0200,4'd0,3'd0,2'd0,2'd0,1,4'd7},        // R7 clean purge
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd5,8'hFF,8'hFF,0,CU,7'h7F,16'h0200,4'd0,3'd2,2'd2,2'd0,1,4'd4},         // R4
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd5,8'd9,8'hFF,0,CU,7'h7F,16'h0200,4'd0,3'd1,2'd1,2'd0,1,4'd3},          // R3
    '{0,3,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd40,8'hFF,8'hFF,0,CU,7'h7F,16'h0200,4'd0,3'd2,2'd2,2'd0,1,4'd2},        // R2 high half
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd3,8'd7,8'd50,0,CU,7'h7F,16'h0200,4'd0,3'd1,2'd1,2'd0,1,4'd2},          // R2 UE over CE
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd3,8'd7,8'hFF,0,CU,7'h7D,16'h0200,4'd0,3'd0,2'd0,2'd0,1,4'd3},          // R3 gate
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd5,8'hFF,8'hFF,0,CU,7'h77,16'h0200,4'd0,3'd0,2'd0,2'd0,1,4'd4},         // R4 gate
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd3,8'd7,8'hFF,0,CU,7'h7E,16'h0200,4'd0,3'd0,2'd0,2'd0,1,4'd2},          // R2 no fall-through
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'hFF,8'hFF,8'hFF,1,CU,7'h7F,16'h0200,4'd0,3'd3,2'd3,2'd0,1,4'd5},        // R5 all user
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'hFF,8'hFF,8'hFF,1,24'h261251,7'h7F,16'h0200,4'd0,3'd3,2'd3,2'd2,1,4'd5}, // R5 hpriv
    '{0,2,8'hDF,8'h00,16'h0100,8'hFF,D0,8'hFF,8'hFF,8'hFF,1,24'h261251,7'h7F,16'h0200,4'd0,3'd3,2'd3,2'd1,1,4'd5}, // R5 invalid hpriv skipped
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'hFF,8'hFF,8'hFF,1,24'h2C9249,7'h7F,16'h0200,4'd0,3'd3,2'd3,2'd3,1,4'd6}, // R6 malformed
    '{0,2,8'hBF,8'h00,16'h0100,8'hFF,D0,8'hFF,8'hFF,8'hFF,1,24'h2C9249,7'h7F,16'h0200,4'd0,3'd3,2'd3,2'd0,1,4'd6}, // R6 malformed invalid
    '{0,2,8'hFF,8'h00,16'h0100,8'hFF,D0,8'd3,8'd7,8'hFF,1,CU,7'h7F,16'h0200,4'd0,3'd3,2'd3,2'd0,1,4'd5},          // R5 parity over data
    '{0,2,8'hFB,8'h00,16'h0100,8'hFF,D0,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0200,4'd0,3'd0,2'd0,2'd0,0,4'd1},          // R1 invalid
    '{0,2,8'hFF,8'h04,16'h0100,8'hFF,D0,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0200,4'd0,3'd0,2'd0,2'd0,0,4'd1},          // R1 ASI
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0104,4'd2,3'd4,2'd3,2'd0,0,4'd9},          // R9 UE
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd64,8'hFF,8'hFF,0,CU,7'h7F,16'h0104,4'd2,3'd5,2'd3,2'd0,0,4'd9},        // R9 CE
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd64,8'hFF,8'hFF,0,CU,7'h3F,16'h0104,4'd2,3'd0,2'd0,2'd0,0,4'd9},        // R9 gate
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0108,4'd4,3'd0,2'd0,2'd0,0,4'd8},          // R8 past end
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h00FC,4'd4,3'd4,2'd3,2'd0,0,4'd8},          // R8 touches start
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h00FB,4'd4,3'd0,2'd0,2'd0,0,4'd8},          // R8 one short
    '{1,4,8'hFF,8'h00,16'h0100,8'h30,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0106,4'd0,3'd0,2'd0,2'd0,0,4'd8},          // R8 partial marks miss
    '{1,4,8'hFF,8'h00,16'h0100,8'h30,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0105,4'd0,3'd4,2'd3,2'd0,0,4'd8},          // R8 partial marks hit
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'hFF,8'hFF,8'hFF,1,CU,7'h7F,16'h0104,4'd2,3'd0,2'd0,2'd0,0,4'd12},       // R12 parity ignored
    '{1,4,8'hFF,8'h10,16'h0100,8'hFF,D1,8'd3,8'd7,8'hFF,0,CU,7'h7F,16'h0104,4'd2,3'd0,2'd0,2'd0,0,4'd1},          // R1 ASI load
    '{1,4,8'hFF,8'h00,16'h0100,8'hFF,D1,8'd3,8'd7,8'd50,0,CU,7'h6F,16'h0104,4'd2,3'd0,2'd0,2'd0,0,4'd2}           // R2 load precedence
  };

  logic        clk, rst_ni;
  logic        req_vld_i, req_op_i, ent_cpar_i, rec_clr_i;
  logic [2:0]  ent_idx_i;
  logic [15:0] ent_addr_i, ld_addr_i;
  logic [7:0]  ent_bmask_i, valid_i, asi_i;
  logic [63:0] ent_data_i;
  logic [13:0] ent_ecc_i;
  logic [23:0] ctl_i;
  logic [6:0]  en_i;
  logic [3:0]  ld_size_i;
  logic        evt_o, inval_o, rec_vld_o, rec_multi_o;
  logic [2:0]  err_type_o, rec_type_o, err_idx_o, inval_idx_o, rec_idx_o;
  logic [1:0]  priv_o, class_o, rec_priv_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  sb_err_check u_sb_err_check (
    .clk_i(clk), .rst_ni(rst_ni), .req_vld_i(req_vld_i), .req_op_i(req_op_i),
    .ent_idx_i(ent_idx_i), .ent_addr_i(ent_addr_i), .ent_bmask_i(ent_bmask_i),
    .ent_cpar_i(ent_cpar_i), .ent_data_i(ent_data_i), .ent_ecc_i(ent_ecc_i),
    .valid_i(valid_i), .asi_i(asi_i), .ctl_i(ctl_i), .en_i(en_i),
    .ld_addr_i(ld_addr_i), .ld_size_i(ld_size_i), .rec_clr_i(rec_clr_i),
    .evt_o(evt_o), .err_type_o(err_type_o), .err_idx_o(err_idx_o), .priv_o(priv_o),
    .class_o(class_o), .inval_o(inval_o), .inval_idx_o(inval_idx_o),
    .rec_vld_o(rec_vld_o), .rec_type_o(rec_type_o), .rec_idx_o(rec_idx_o),
    .rec_priv_o(rec_priv_o), .rec_multi_o(rec_multi_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [6:0] tb_ecc(input logic [31:0] d);
    logic [5:0] c;
    int pos;
    c   = '0;
    pos = 2;
    for (int j = 0; j < 32; j++) begin
      pos++;
      while ((pos & (pos - 1)) == 0) pos++;
      for (int k = 0; k < 6; k++) if (((pos >> k) & 1) == 1) c[k] = c[k] ^ d[j];
    end
    return {(^d) ^ (^c), c};
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v, input logic clr);
    logic [77:0] cw;
    cw = {tb_ecc(v.data[63:32]), tb_ecc(v.data[31:0]), v.data};
    if (v.fa != 8'hFF) cw[v.fa] = ~cw[v.fa];
    if (v.fb != 8'hFF) cw[v.fb] = ~cw[v.fb];
    if (v.fc != 8'hFF) cw[v.fc] = ~cw[v.fc];
    @(negedge clk);
    req_vld_i   = 1'b1;
    req_op_i    = v.op;
    ent_idx_i   = v.idx;
    valid_i     = v.valid;
    asi_i       = v.asi;
    ent_addr_i  = v.addr;
    ent_bmask_i = v.bm;
    ent_cpar_i  = (^v.addr) ^ (^v.bm) ^ v.pflip;
    ent_data_i  = cw[63:0];
    ent_ecc_i   = cw[77:64];
    ctl_i       = v.ctl;
    en_i        = v.en;
    ld_addr_i   = v.ld_addr;
    ld_size_i   = v.ld_size;
    rec_clr_i   = clr;
    @(negedge clk);
    req_vld_i = 1'b0;
    rec_clr_i = 1'b0;
  endtask

  task automatic pulse_clear();
    @(negedge clk);
    rec_clr_i = 1'b1;
    @(negedge clk);
    rec_clr_i = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
    end
  end

  initial begin
    rst_ni = 1'b0; req_vld_i = 0; req_op_i = 0; rec_clr_i = 0; ent_idx_i = 0;
    ent_addr_i = 0; ent_bmask_i = 0; ent_cpar_i = 0; ent_data_i = 0; ent_ecc_i = 0;
    valid_i = 0; asi_i = 0; ctl_i = 0; en_i = 0; ld_addr_i = 0; ld_size_i = 0;
    repeat (3) @(negedge clk);
    chk("R10", "reset evt", 32'(evt_o), 0);
    chk("R10", "reset inval", 32'(inval_o), 0);
    chk("R11", "reset rec_vld", 32'(rec_vld_o), 0);
    chk("R11", "reset multi", 32'(rec_multi_o), 0);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      string rq;
      rq = $sformatf("R%0d vec%0d", VECS[i].req, i);
      pulse_clear();
      drive(VECS[i], 1'b0);
      chk(rq, "evt", 32'(evt_o), 32'(VECS[i].x_type != 0));
      chk(rq, "type", 32'(err_type_o), 32'(VECS[i].x_type));
      chk(rq, "class", 32'(class_o), 32'(VECS[i].x_cls));
      chk(rq, "priv", 32'(priv_o), 32'(VECS[i].x_priv));
      chk(rq, "inval", 32'(inval_o), 32'(VECS[i].x_inv));
      if (VECS[i].x_type != 0) chk(rq, "idx", 32'(err_idx_o), 32'(VECS[i].idx));
      if (VECS[i].x_inv) chk(rq, "inval_idx", 32'(inval_idx_o), 32'(VECS[i].idx));
      chk(rq, "R11 rec_vld", 32'(rec_vld_o), 32'(VECS[i].x_type != 0));
    end

    // R10: report is a single-cycle pulse
    pulse_clear();
    drive(VECS[2], 1'b0);
    chk("R10", "evt first cycle", 32'(evt_o), 1);
    @(negedge clk);
    chk("R10", "evt second cycle", 32'(evt_o), 0);
    chk("R10", "type idle", 32'(err_type_o), 0);

    // R11: second report flags multiple, record keeps first
    drive(VECS[9], 1'b0);
    chk("R11", "second evt", 32'(evt_o), 1);
    chk("R11", "kept type", 32'(rec_type_o), 1);
    chk("R11", "kept idx", 32'(rec_idx_o), 2);
    chk("R11", "kept priv", 32'(rec_priv_o), 0);
    chk("R11", "multi set", 32'(rec_multi_o), 1);

    pulse_clear();
    chk("R11", "cleared vld", 32'(rec_vld_o), 0);
    chk("R11", "cleared multi", 32'(rec_multi_o), 0);

    // R11: clear with report in the same cycle captures the new one
    drive(VECS[9], 1'b0);
    drive(VECS[1], 1'b1);
    chk("R11", "clr+rpt vld", 32'(rec_vld_o), 1);
    chk("R11", "clr+rpt type", 32'(rec_type_o), 2);
    chk("R11", "clr+rpt multi", 32'(rec_multi_o), 0);

    done = 1;
    finish_run();
  end
endmodule